// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is an I2C target that answers the read transactions of a serial EEPROM in front of an on-chip byte array. It watches the open-drain clock and data lines through two-flop synchronisers and finds Start, repeated Start and Stop conditions. It decodes the device select byte. A host may load a two-byte address with a dummy write. It then reads one or more bytes, either after a repeated Start or in a later transaction. The only thing the block drives on the bus is a pull-low enable for the data line.

A single address counter serves every read form. A current-address read continues from wherever the counter stands. A random read first reloads the counter with a dummy write. A sequential read keeps returning bytes for as long as the host acknowledges them. The counter keeps its value across transactions. It moves on by one after every byte sent and wraps at the top of the array. A synchronous side port fills the array for test. It is a valid/ready stream: a byte is written on a cycle where `pl_valid` and `pl_ready` are both high. `pl_ready` is high only while the target is in standby, so a busy bus back-pressures the port, and the source must hold its byte until it is taken.

`ADDR_W` sets the array size. `ADDR_W = 14` gives the full 16384-byte array. The default of 11 keeps the elaborated array small. The system clock must give each SCL high and low phase at least `SYNC_STAGES + 3` cycles.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, `sda_oe` is low, the address counter is 0, the target is in standby and `pl_ready` is high.
- R2: A Start or Stop is recognised when SDA changes while SCL is high. After a Stop the target ignores clocked bytes until a Start. The target changes `sda_oe` only while SCL is low.
- R3: The target acknowledges a device select byte whose upper four bits are 1010, whatever the next three bits are. Bit 0 is RW, where 1 means read. On any other upper nibble it does not acknowledge, and it leaves SDA released until the next Start.
- R4: After a select with RW=0, the target acknowledges two address bytes, sent high byte first and MSB first. The counter loads with {high byte[ADDR_W-9:0], low byte} when the low byte completes. High-byte bits above ADDR_W-9 are ignored.
- R5: After the address bytes, a repeated Start and a select with RW=1 are acknowledged, and the byte at the loaded address is returned.
- R6: A Start followed at once by a select with RW=1 returns the byte at the counter's present address.
- R7: The counter advances by one after every byte sent, whether the host then acknowledges it or not, and keeps its value between transactions.
- R8: In a read, each host ACK (SDA low on the 9th clock) makes the target send the next byte at once.
- R9: A host NACK (SDA high on the 9th clock) returns the target to standby. It keeps SDA released and raises `pl_ready` until the next Start.
- R10: The counter wraps from 2^ADDR_W-1 to 0 during a sequential read.
- R11: A dummy write ended by a Stop keeps the loaded address for the next current-address read.
- R12: A preload byte is written to the array only on a cycle where `pl_valid` and `pl_ready` are both high. `pl_ready` is low from a Start until the target returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, pulls SDA low |
| pl_valid | input | 1 | Preload byte is valid |
| pl_ready | output | 1 | Preload byte is accepted this cycle |
| pl_addr | input | ADDR_W | Preload array address |
| pl_data | input | 8 | Preload byte |

## Verification
Most internal faults show on SDA within one byte time. A wrong counter value returns the wrong data byte in the very next read. A state machine stuck out of standby leaves `pl_ready` low and never acknowledges the next select. A wrong bit count shifts the returned data by one bit position, or moves the acknowledge away from the 9th clock. The bench therefore compares every returned byte and every acknowledge against an address it tracks on its own. It also checks that SDA stays released whenever the target should be silent.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,      // standby, wait for a Start
    ST_RX,        // shifting in a byte from the host
    ST_ACK_WAIT,  // byte taken, wait for SCL low to pull SDA
    ST_ACK,       // holding the acknowledge for the 9th clock
    ST_TX,        // shifting a data byte out
    ST_MACK,      // released, sampling the host acknowledge
    ST_NEXT,      // host acknowledged, start next byte on SCL low
    ST_HOLD       // address loaded, wait for repeated Start or Stop
  } rd_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO
  } rx_kind_e;

  localparam logic [3:0] SELECT_CODE = 4'b1010;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rd_addr.sv
module i2c_rd_addr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  // R10: stepping past the last byte lands on byte 0
  assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc) && !$past(load) && $past(cnt) == TOP) |-> cnt == '0);

  // R4: a completed address write is what the counter holds next
  assert_load_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> cnt == $past(load_val));
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader import i2c_rd_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  rd_state_e state;
  rx_kind_e  rx_kind;
  logic [3:0] bit_cnt;
  logic [6:0] shreg;
  logic [6:0] tx_q;
  logic [HI_W-1:0] hi_q;
  logic rw_q;
  logic [7:0] rx_byte, rdata;
  logic [ADDR_W-1:0] addr_cnt;
  logic ctr_load, ctr_inc;

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_byte  = {shreg, sda_s};
  assign ctr_load = (state == ST_RX) && scl_rise && (bit_cnt == 4'd7) && (rx_kind == RX_ALO);
  assign ctr_inc  = (state == ST_MACK) && scl_rise;

  i2c_rd_addr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val({hi_q, rx_byte}), .inc(ctr_inc), .cnt(addr_cnt)
  );

  assign pl_ready = (state == ST_IDLE);

  i2c_rd_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(pl_valid & pl_ready), .waddr(pl_addr), .wdata(pl_data),
    .raddr(addr_cnt), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx_kind <= RX_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      tx_q    <= '0;
      hi_q    <= '0;
      rw_q    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      rx_kind <= RX_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            bit_cnt <= '0;
            unique case (rx_kind)
              RX_DEV: begin
                if (rx_byte[7:4] == SELECT_CODE) begin
                  rw_q  <= rx_byte[0];
                  state <= ST_ACK_WAIT;
                end else begin
                  state <= ST_IDLE;
                end
              end
              RX_AHI: begin
                hi_q  <= rx_byte[HI_W-1:0];
                state <= ST_ACK_WAIT;
              end
              default: state <= ST_ACK_WAIT;
            endcase
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          if (rx_kind == RX_DEV && rw_q) begin
            tx_q    <= rdata[6:0];
            sda_oe  <= ~rdata[7];
            bit_cnt <= '0;
            state   <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            unique case (rx_kind)
              RX_DEV: begin rx_kind <= RX_AHI; state <= ST_RX; end
              RX_AHI: begin rx_kind <= RX_ALO; state <= ST_RX; end
              default: state <= ST_HOLD;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~tx_q[3'(4'd7 - bit_cnt)];
            end
          end
        end
        ST_MACK: if (scl_rise) state <= sda_s ? ST_IDLE : ST_NEXT;
        ST_NEXT: if (scl_fall) begin
          tx_q    <= rdata[6:0];
          sda_oe  <= ~rdata[7];
          bit_cnt <= '0;
          state   <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  // R2: the data line is only moved while the clock is low
  assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R9: in standby the target never pulls the line
  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: while the host is sending a byte the line is released
  assert_rx_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX) |-> !sda_oe);
endmodule

// File: tb/i2c_eeprom_reader_test.sv
module i2c_eeprom_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic pl_valid = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic sda_oe, pl_ready;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  logic [AW-1:0] exp_addr;

  assign sda_line = ~(host_low | sda_oe);

  i2c_eeprom_reader #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    pat = (a[7:0] * 8'd7 + 8'h3C) ^ {5'd0, a[10:8]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic v, output logic s);
    host_low = ~v;
    qwait(); scl = 1'b1;
    qwait(); s = sda_line;
    qwait(); scl = 1'b0;
    qwait();
  endtask

  task automatic bus_start();
    host_low = 1'b0;
    qwait(); scl = 1'b1;
    qwait(); host_low = 1'b1;
    qwait(); scl = 1'b0;
    qwait();
  endtask

  task automatic bus_stop();
    host_low = 1'b1;
    qwait(); scl = 1'b1;
    qwait(); host_low = 1'b0;
    qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~host_ack, s);
  endtask

  task automatic preload(input logic [AW-1:0] a);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = a; pl_data = pat(a);
    chk("R12 preload ready in standby", {31'd0, pl_ready}, 32'd1);
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  // dummy write of hi/lo, optional Stop afterwards
  task automatic set_addr(input logic [7:0] dev, input logic [7:0] hi,
                          input logic [7:0] lo, input logic with_stop);
    logic ack;
    bus_start();
    send_byte(dev, ack); chk("R3 select write ack", {31'd0, ack}, 32'd1);
    send_byte(hi, ack);  chk("R4 high address ack", {31'd0, ack}, 32'd1);
    send_byte(lo, ack);  chk("R4 low address ack", {31'd0, ack}, 32'd1);
    if (with_stop) bus_stop();
  endtask

  // read n bytes after a Start (repeated or fresh); last one NACKed, then Stop
  task automatic read_bytes(input logic [7:0] dev, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev | 8'h01, ack);
    chk({tag, " select read ack"}, {31'd0, ack}, 32'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk({tag, " data"}, {24'd0, d}, {24'd0, pat(exp_addr)});
      exp_addr = exp_addr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 pl_ready after reset", {31'd0, pl_ready}, 32'd1);
    exp_addr = '0;
    read_bytes(8'hA0, 1, "R1 counter zero");
  endtask

  task automatic t_random();
    set_addr(8'hA0, 8'h00, 8'h04, 1'b0);
    exp_addr = 11'h004;
    read_bytes(8'hA0, 1, "R5 random read");
  endtask

  task automatic t_current();
    read_bytes(8'hA2, 1, "R6 R7 current read");
  endtask

  task automatic t_sequential();
    set_addr(8'hAE, 8'h01, 8'h20, 1'b0);
    exp_addr = 11'h120;
    read_bytes(8'hAE, 4, "R8 sequential");
    read_bytes(8'hA0, 2, "R7 persistent counter");
  endtask

  task automatic t_wrap();
    set_addr(8'hA0, 8'h07, 8'hFE, 1'b0);
    exp_addr = 11'h7FE;
    read_bytes(8'hA0, 4, "R10 wrap");
    chk("R10 counter after wrap", {21'd0, exp_addr}, 32'd2);
  endtask

  task automatic t_dummy_stop();
    set_addr(8'hA0, 8'h00, 8'h03, 1'b1);
    exp_addr = 11'h003;
    read_bytes(8'hA0, 1, "R11 dummy write then stop");
  endtask

  task automatic t_wrong_select();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'h91, ack);
    chk("R3 wrong select no ack", {31'd0, ack}, 32'd0);
    recv_byte(1'b0, d);
    chk("R3 line released after mismatch", {24'd0, d}, 32'hFF);
    bus_stop();
    read_bytes(8'hA0, 1, "R3 counter untouched");
  endtask

  task automatic t_nack_standby();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ack);
    chk("R9 select ack", {31'd0, ack}, 32'd1);
    recv_byte(1'b0, d);
    chk("R9 data before nack", {24'd0, d}, {24'd0, pat(exp_addr)});
    exp_addr = exp_addr + 1'b1;
    chk("R9 pl_ready in standby", {31'd0, pl_ready}, 32'd1);
    recv_byte(1'b0, d);
    chk("R9 quiet after nack", {24'd0, d}, 32'hFF);
    bus_stop();
    read_bytes(8'hA0, 1, "R9 R7 single advance");
  endtask

  task automatic t_after_stop();
    logic ack;
    scl = 1'b0;
    qwait();
    send_byte(8'hA1, ack);
    chk("R2 byte after stop ignored", {31'd0, ack}, 32'd0);
    bus_stop();
    read_bytes(8'hA0, 1, "R2 counter after ignored byte");
  endtask

  task automatic t_busy_preload();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack);
    chk("R12 select ack", {31'd0, ack}, 32'd1);
    @(negedge clk);
    chk("R12 pl_ready low while busy", {31'd0, pl_ready}, 32'd0);
    pl_valid = 1'b1; pl_addr = '0; pl_data = 8'hEE;
    repeat (4) @(negedge clk);
    pl_valid = 1'b0;
    bus_stop();
    set_addr(8'hA0, 8'h00, 8'h00, 1'b0);
    exp_addr = '0;
    read_bytes(8'hA0, 1, "R12 busy write refused");
  endtask

  task automatic t_high_bits();
    set_addr(8'hA4, 8'hF9, 8'h23, 1'b0);
    exp_addr = 11'h123;
    read_bytes(8'hA4, 1, "R4 unused high bits");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) preload(11'(a));
    for (int a = 'h120; a < 'h128; a++) preload(11'(a));
    preload(11'h7FE);
    preload(11'h7FF);
    t_reset();
    t_random();
    t_current();
    t_sequential();
    t_wrap();
    t_dummy_stop();
    t_wrong_select();
    t_nack_standby();
    t_after_stop();
    t_busy_preload();
    t_high_bits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule